// File: doc/BRIEF.md
# Register Producer Tag Table

This block keeps, for every architectural floating-point register, the register's current value and a small producer tag. The tag names the reservation station whose result will become that register's next value. A tag of zero means the stored value is current. The block is placed beside the issue stage of an out-of-order core.

When an instruction issues, two source ports look up its operands. Each source gets either a ready value with a zero tag, or the nonzero tag of the station it must wait for. In the same cycle the destination register is renamed: its tag is overwritten with the tag of the station that accepted the instruction. Because the tag is overwritten this way, later writers never stall behind earlier readers or earlier writers.

A result broadcast carries a station tag and a value. Every register whose tag equals the broadcast tag takes the value and returns to the ready state. A register that a younger instruction has already renamed keeps its newer tag and ignores the older result.

Top module: `rstab_rename_table`

## Requirements
- R1: After synchronous reset, every register reads back with tag 0 and value 0 on both source ports.
- R2: A source lookup of a register whose tag is 0 returns the stored value with tag 0.
- R3: A source lookup of a register whose tag is nonzero, and which is not matched by a broadcast in that cycle, returns that tag.
- R4: An issue with `iss_valid`=1, `iss_dst_we`=1 and a nonzero `iss_dst_tag` sets the destination register's tag to `iss_dst_tag`, visible from the next cycle.
- R5: A broadcast with `bc_valid`=1 and a nonzero `bc_tag` writes `bc_value` into every register whose tag equals `bc_tag` and clears their tags to 0. The update is visible from the next cycle, and several registers can be updated at once.
- R6: A broadcast does not change the value or tag of a register whose tag differs from `bc_tag`. This includes a register that was renamed to a newer tag before the older result arrived.
- R7: When a broadcast matches a looked-up register's tag in the same cycle, the source port returns `bc_value` with tag 0.
- R8: When a broadcast clears a register and an issue renames the same register in the same cycle, the register ends with the issue's tag.
- R9: A broadcast with tag 0 changes no register, and an issue destination write with tag 0 changes no register.
- R10: Source lookups in an issue cycle return the state from before that issue's own destination rename.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| iss_valid | input | 1 | An instruction issues this cycle |
| iss_dst_we | input | 1 | The issuing instruction writes a destination register |
| iss_dst_idx | input | 4 | Destination register number |
| iss_dst_tag | input | 3 | Station tag assigned to the issuing instruction |
| src_a_idx | input | 4 | First source register number |
| src_b_idx | input | 4 | Second source register number |
| src_a_val | output | 32 | First source value, meaningful when src_a_tag is 0 |
| src_a_tag | output | 3 | First source producer tag, 0 when ready |
| src_b_val | output | 32 | Second source value, meaningful when src_b_tag is 0 |
| src_b_tag | output | 3 | Second source producer tag, 0 when ready |
| bc_valid | input | 1 | A result broadcast is present |
| bc_tag | input | 3 | Tag of the station producing the broadcast |
| bc_value | input | 32 | Broadcast result value |

## Verification
Both source ports are combinational, so a wrong tag or value inside any entry shows up in the same cycle that entry is looked up. No delay hides a fault. If a broadcast matched a stale or zero tag, a register that should be untouched would read back with the wrong value on the first lookup after the broadcast edge. If the priority between issue and broadcast were reversed, a renamed register would read back with tag 0 one cycle after the collision, instead of showing the new station tag.

// File: rtl/rstab_pkg.sv
`timescale 1ns/1ps
package rstab_pkg;
    localparam int REG_COUNT = 16;
    localparam int TAG_BITS  = 3;
    localparam int DATA_BITS = 32;
    localparam int IDX_BITS  = $clog2(REG_COUNT);
    localparam int SRC_PORTS = 2;

    typedef logic [TAG_BITS-1:0]  tag_t;
    typedef logic [DATA_BITS-1:0] word_t;
    typedef logic [IDX_BITS-1:0]  idx_t;

    localparam tag_t NO_PRODUCER = '0;

    typedef struct packed {
        logic  valid;
        tag_t  tag;
        word_t value;
    } bcast_t;

    typedef struct packed {
        logic valid;
        logic dst_we;
        idx_t dst_idx;
        tag_t dst_tag;
    } rename_req_t;

    typedef struct packed {
        tag_t  qi;
        word_t value;
    } entry_t;

    typedef enum logic [1:0] {
        SRC_FILE,
        SRC_BYPASS,
        SRC_PENDING
    } src_kind_e;

    function automatic logic bcast_hits(bcast_t b, tag_t qi);
        return b.valid && (b.tag != NO_PRODUCER) && (b.tag == qi);
    endfunction

    function automatic logic req_claims(rename_req_t r, idx_t which);
        return r.valid && r.dst_we && (r.dst_tag != NO_PRODUCER) && (r.dst_idx == which);
    endfunction
endpackage

// File: rtl/rstab_entry.sv
`timescale 1ns/1ps
module rstab_entry
    import rstab_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  bcast_t bc_i,
    input  logic   claim_i,
    input  tag_t   claim_tag_i,
    output entry_t state_o
);
    entry_t state_q;
    logic   hit;

    assign hit = bcast_hits(bc_i, state_q.qi);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= '0;
        end else begin
            if (hit) begin
                state_q.value <= bc_i.value;
            end
            if (claim_i) begin
                state_q.qi <= claim_tag_i;
            end else if (hit) begin
                state_q.qi <= NO_PRODUCER;
            end
        end
    end

    assign state_o = state_q;

    // R5: a matching broadcast leaves the entry ready with the broadcast value
    p_bcast_clears_r5: assert property (@(posedge clk) disable iff (rst)
        (bcast_hits(bc_i, state_o.qi) && !claim_i) |=>
            (state_o.qi == NO_PRODUCER) && (state_o.value == $past(bc_i.value)));

    // R6: a non-matching broadcast leaves the entry untouched
    p_stale_ignored_r6: assert property (@(posedge clk) disable iff (rst)
        (!bcast_hits(bc_i, state_o.qi) && !claim_i) |=>
            ($stable(state_o.qi) && $stable(state_o.value)));

    // R8: a rename in the same cycle as a clearing broadcast keeps the new tag
    p_issue_wins_r8: assert property (@(posedge clk) disable iff (rst)
        claim_i |=> (state_o.qi == $past(claim_tag_i)));
endmodule

// File: rtl/rstab_lookup.sv
`timescale 1ns/1ps
module rstab_lookup
    import rstab_pkg::*;
(
    input  idx_t   idx_i,
    input  entry_t table_i [REG_COUNT],
    input  bcast_t bc_i,
    output word_t  value_o,
    output tag_t   tag_o
);
    entry_t    cur;
    src_kind_e kind;

    always_comb begin
        cur = table_i[idx_i];
        if (cur.qi == NO_PRODUCER) begin
            kind = SRC_FILE;
        end else if (bcast_hits(bc_i, cur.qi)) begin
            kind = SRC_BYPASS;
        end else begin
            kind = SRC_PENDING;
        end
        case (kind)
            SRC_FILE: begin
                value_o = cur.value;
                tag_o   = NO_PRODUCER;
            end
            SRC_BYPASS: begin
                value_o = bc_i.value;
                tag_o   = NO_PRODUCER;
            end
            default: begin
                value_o = cur.value;
                tag_o   = cur.qi;
            end
        endcase
    end
endmodule

// File: rtl/rstab_rename_table.sv
`timescale 1ns/1ps
module rstab_rename_table
    import rstab_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 iss_valid,
    input  logic                 iss_dst_we,
    input  logic [IDX_BITS-1:0]  iss_dst_idx,
    input  logic [TAG_BITS-1:0]  iss_dst_tag,
    input  logic [IDX_BITS-1:0]  src_a_idx,
    input  logic [IDX_BITS-1:0]  src_b_idx,
    output logic [DATA_BITS-1:0] src_a_val,
    output logic [TAG_BITS-1:0]  src_a_tag,
    output logic [DATA_BITS-1:0] src_b_val,
    output logic [TAG_BITS-1:0]  src_b_tag,
    input  logic                 bc_valid,
    input  logic [TAG_BITS-1:0]  bc_tag,
    input  logic [DATA_BITS-1:0] bc_value
);
    bcast_t      bc;
    rename_req_t req;
    entry_t      table_q [REG_COUNT];
    idx_t        port_idx [SRC_PORTS];
    word_t       port_val [SRC_PORTS];
    tag_t        port_tag [SRC_PORTS];

    assign bc  = '{valid: bc_valid, tag: bc_tag, value: bc_value};
    assign req = '{valid: iss_valid, dst_we: iss_dst_we, dst_idx: iss_dst_idx, dst_tag: iss_dst_tag};

    generate
        for (genvar g = 0; g < REG_COUNT; g++) begin : g_entry
            rstab_entry u_entry (
                .clk         (clk),
                .rst         (rst),
                .bc_i        (bc),
                .claim_i     (req_claims(req, idx_t'(g))),
                .claim_tag_i (req.dst_tag),
                .state_o     (table_q[g])
            );
        end
    endgenerate

    assign port_idx[0] = src_a_idx;
    assign port_idx[1] = src_b_idx;

    generate
        for (genvar p = 0; p < SRC_PORTS; p++) begin : g_port
            rstab_lookup u_lookup (
                .idx_i   (port_idx[p]),
                .table_i (table_q),
                .bc_i    (bc),
                .value_o (port_val[p]),
                .tag_o   (port_tag[p])
            );
        end
    endgenerate

    assign src_a_val = port_val[0];
    assign src_a_tag = port_tag[0];
    assign src_b_val = port_val[1];
    assign src_b_tag = port_tag[1];

    // R7: a live broadcast tag is never reported as still pending
    p_bypass_a_r7: assert property (@(posedge clk) disable iff (rst)
        (bc_valid && bc_tag != NO_PRODUCER) |-> (src_a_tag != bc_tag));
    p_bypass_b_r7: assert property (@(posedge clk) disable iff (rst)
        (bc_valid && bc_tag != NO_PRODUCER) |-> (src_b_tag != bc_tag));

    // R4: a renamed destination reads back with its new tag one cycle later
    p_rename_visible_r4: assert property (@(posedge clk) disable iff (rst)
        (iss_valid && iss_dst_we && iss_dst_tag != NO_PRODUCER) |=>
            ((src_a_idx != $past(iss_dst_idx)) ||
             (bc_valid && bc_tag == $past(iss_dst_tag)) ||
             (src_a_tag == $past(iss_dst_tag))));
endmodule

// File: tb/rstab_rename_table_tb_top.sv
`timescale 1ns/1ps
module rstab_rename_table_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        iss_valid = 1'b0, iss_dst_we = 1'b0;
    logic [3:0]  iss_dst_idx = '0, src_a_idx = '0, src_b_idx = '0;
    logic [2:0]  iss_dst_tag = '0, bc_tag = '0;
    logic        bc_valid = 1'b0;
    logic [31:0] bc_value = '0;
    logic [31:0] src_a_val, src_b_val;
    logic [2:0]  src_a_tag, src_b_tag;

    int compared = 0;
    int mismatched = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    rstab_rename_table dut_i (
        .clk(clk), .rst(rst),
        .iss_valid(iss_valid), .iss_dst_we(iss_dst_we),
        .iss_dst_idx(iss_dst_idx), .iss_dst_tag(iss_dst_tag),
        .src_a_idx(src_a_idx), .src_b_idx(src_b_idx),
        .src_a_val(src_a_val), .src_a_tag(src_a_tag),
        .src_b_val(src_b_val), .src_b_tag(src_b_tag),
        .bc_valid(bc_valid), .bc_tag(bc_tag), .bc_value(bc_value)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        compared++;
        if (!ok) begin
            mismatched++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // drive one cycle of stimulus at a falling edge, let it pass the rising edge
    task automatic cyc(input bit iv, input logic [3:0] d, input logic [2:0] t,
                       input bit bv, input logic [2:0] bt, input logic [31:0] bval);
        iss_valid = iv; iss_dst_we = iv; iss_dst_idx = d; iss_dst_tag = t;
        bc_valid = bv; bc_tag = bt; bc_value = bval;
        @(posedge clk); @(negedge clk);
        iss_valid = 0; iss_dst_we = 0; bc_valid = 0;
    endtask

    task automatic look(input logic [3:0] r, input logic [2:0] et, input logic [31:0] ev,
                        input bit cmp_val, input string req);
        src_a_idx = r; src_b_idx = r; #1;
        chk(src_a_tag == et, {req, " tag a"}, 32'(src_a_tag), 32'(et));
        chk(src_b_tag == et, {req, " tag b"}, 32'(src_b_tag), 32'(et));
        if (cmp_val) chk(src_a_val == ev, {req, " value"}, src_a_val, ev);
    endtask

    task automatic t_reset();
        for (int r = 0; r < 16; r++) begin
            src_a_idx = 4'(r); src_b_idx = 4'(15 - r); #0.1;
            chk(src_a_tag == 0 && src_a_val == 0 && src_b_tag == 0 && src_b_val == 0,
                "R1 reset", {src_a_tag, src_a_val[28:0]}, 32'h0);
        end
    endtask

    task automatic t_basic();
        cyc(1, 4'd3, 3'd2, 0, 3'd0, 32'h0);
        look(4'd3, 3'd2, 32'h0, 0, "R4/R3 rename");
        cyc(0, 4'd0, 3'd0, 1, 3'd2, 32'h0000AAAA);
        look(4'd3, 3'd0, 32'h0000AAAA, 1, "R5/R2 writeback");
    endtask

    task automatic t_multi();
        cyc(1, 4'd4, 3'd5, 0, 3'd0, 32'h0);
        cyc(1, 4'd6, 3'd5, 0, 3'd0, 32'h0);
        cyc(0, 4'd0, 3'd0, 1, 3'd5, 32'h00001234);
        look(4'd4, 3'd0, 32'h00001234, 1, "R5 multi reg4");
        look(4'd6, 3'd0, 32'h00001234, 1, "R5 multi reg6");
    endtask

    task automatic t_stale();
        cyc(1, 4'd7, 3'd1, 0, 3'd0, 32'h0);
        cyc(1, 4'd7, 3'd3, 0, 3'd0, 32'h0);
        cyc(0, 4'd0, 3'd0, 1, 3'd1, 32'h0000DEAD);
        look(4'd7, 3'd3, 32'h0, 0, "R6 retargeted");
        look(4'd3, 3'd0, 32'h0000AAAA, 1, "R6 ready reg untouched");
        cyc(0, 4'd0, 3'd0, 1, 3'd3, 32'h0000BEEF);
        look(4'd7, 3'd0, 32'h0000BEEF, 1, "R6 newer result lands");
    endtask

    task automatic t_bypass();
        cyc(1, 4'd8, 3'd4, 0, 3'd0, 32'h0);
        bc_valid = 1; bc_tag = 3'd4; bc_value = 32'h00000055;
        look(4'd8, 3'd0, 32'h00000055, 1, "R7 forward");
        @(posedge clk); @(negedge clk);
        bc_valid = 0;
        look(4'd8, 3'd0, 32'h00000055, 1, "R7 stored after forward");
    endtask

    task automatic t_collide();
        cyc(1, 4'd9, 3'd6, 0, 3'd0, 32'h0);
        cyc(1, 4'd9, 3'd7, 1, 3'd6, 32'h00000066);
        look(4'd9, 3'd7, 32'h0, 0, "R8 issue wins");
        cyc(0, 4'd0, 3'd0, 1, 3'd7, 32'h00000077);
        look(4'd9, 3'd0, 32'h00000077, 1, "R8 later result");
    endtask

    task automatic t_zero();
        cyc(0, 4'd0, 3'd0, 1, 3'd0, 32'hFFFFFFFF);
        look(4'd3, 3'd0, 32'h0000AAAA, 1, "R9 zero-tag broadcast");
        look(4'd10, 3'd0, 32'h0, 1, "R9 zero-tag broadcast idle reg");
        cyc(1, 4'd10, 3'd0, 0, 3'd0, 32'h0);
        look(4'd10, 3'd0, 32'h0, 1, "R9 zero-tag rename");
    endtask

    task automatic t_own_dest();
        iss_valid = 1; iss_dst_we = 1; iss_dst_idx = 4'd11; iss_dst_tag = 3'd2;
        look(4'd11, 3'd0, 32'h0, 1, "R10 pre-rename read");
        @(posedge clk); @(negedge clk);
        iss_valid = 0; iss_dst_we = 0;
        look(4'd11, 3'd2, 32'h0, 0, "R10 rename after");
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 0;
        t_reset();
        t_basic();
        t_multi();
        t_stale();
        t_bypass();
        t_collide();
        t_zero();
        t_own_dest();
        if (!done) begin
            done = 1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            compared++; mismatched++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end
endmodule